// File: doc/BRIEF.md
# Late Data Merge for a Trace Memory

This block sits in front of a single-ported trace memory and stores records for commands whose data phase arrives some cycles after the command phase. A command record goes to the memory in the same cycle it is presented, with its data-dependent field written as zero. For a command flagged as having data to follow, the block remembers the target entry and its accumulation mode. It then collects the data-phase beats in order and, on the last beat, produces a field update that is merged back into that entry through a bit-select write.

The memory has one write port, and command records always own it. A finished update that cannot be written at once waits in a four-deep side queue. The queue drains, oldest first, on any cycle without a command write. When the queue is full and another update must be parked, the oldest parked update is discarded and a one-cycle drop pulse is raised. The discarded entry keeps its zero field.

The accumulator runs a two-state machine. In ACC_IDLE no beats have been seen for the head command. A non-last beat takes ACC_IDLE to ACC_RUN, further non-last beats stay in ACC_RUN, and a last beat returns it to ACC_IDLE. The port arbiter picks one grant per cycle:
- GNT_CMD, for a command record.
- GNT_QUEUE, for the oldest parked update.
- GNT_DIRECT, for an update finishing this cycle with the port and queue free.
- GNT_NONE, when nothing is written.

Top module: `late_merge_top`

## Requirements
- R1: After reset, with no command and no beat presented, `mem_we` and `mem_drop` are 0.
- R2: When `cmd_valid` is 1, `mem_we` is 1 in that same cycle, `mem_addr` equals `cmd_idx` and `mem_wsel` is all ones.
- R3: In a command write, `mem_wdata` equals `cmd_rec` with the field bits [15:8] forced to zero.
- R4: With `cmd_len_mode` 0 (mask mode), the update value is the OR of `dat_be` over all beats of that command, up to and including the beat with `dat_last` 1.
- R5: With `cmd_len_mode` 1 (length mode), the update value is the number of beats of that command, including the last.
- R6: A field update writes its value into `mem_wdata[15:8]`, with `mem_wsel` equal to 32'h0000FF00 and all other data bits zero. If no command is presented and the queue is empty, it is written in the cycle of its last beat.
- R7: An update completing in a cycle with `cmd_valid` 1 is not written then. It is written in a later cycle without a command.
- R8: While the queue holds updates, a cycle without a command writes the oldest parked update, and an update completing in that cycle is parked behind the others.
- R9: When an update must be parked while four are held and none leaves, the oldest is discarded and never written, and `mem_drop` is 1 for exactly that cycle.
- R10: Beats belong to the oldest command with `cmd_has_data` 1 whose last beat has not arrived. Commands without that flag take no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command record presented this cycle |
| cmd_idx | input | 6 | Memory entry for the record |
| cmd_rec | input | 32 | Command-phase record |
| cmd_has_data | input | 1 | Data beats will follow for this command |
| cmd_len_mode | input | 1 | 1: count beats; 0: OR byte enables |
| dat_valid | input | 1 | Data-phase beat valid |
| dat_be | input | 8 | Byte enables of the beat |
| dat_last | input | 1 | Final beat of the current command |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 6 | Memory write entry |
| mem_wdata | output | 32 | Memory write data |
| mem_wsel | output | 32 | Per-bit write select |
| mem_drop | output | 1 | A parked update was discarded this cycle |

## Verification
Single-beat and multi-beat updates in both modes, with the port idle, show whether accumulation and direct writes are right. Updates that finish under a command show parking and later draining. An unbroken run of commands with an update finishing every cycle fills the queue past its depth. It checks which two updates are lost and the order in which the survivors land. Long random mixes of commands, beats and idle cycles compare every write and drop against a reference of the ordering rules.

// File: rtl/lm_pkg.sv
package lm_pkg;

    typedef enum logic [1:0] {
        GNT_NONE   = 2'd0,
        GNT_CMD    = 2'd1,
        GNT_QUEUE  = 2'd2,
        GNT_DIRECT = 2'd3
    } grant_t;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RUN  = 1'b1
    } acc_state_t;

endpackage

// File: rtl/lm_fifo.sv
module lm_fifo #(
    parameter int W         = 8,
    parameter int DEPTH     = 4,
    parameter bit OVERWRITE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop, do_push, ovw, advance_rd;

    assign empty  = (count == '0);
    assign full   = (count == CNT_W'(DEPTH));
    assign do_pop = pop && !empty;

    generate
        if (OVERWRITE) begin : g_ovw
            assign ovw     = push && full && !do_pop;
            assign do_push = push;
        end else begin : g_hold
            assign ovw     = 1'b0;
            assign do_push = push && (!full || do_pop);
        end
    endgenerate

    assign advance_rd = do_pop || ovw;
    assign drop       = ovw;
    assign dout       = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)    wr_ptr <= bump(wr_ptr);
            if (advance_rd) rd_ptr <= bump(rd_ptr);
            if (do_push && !advance_rd)      count <= count + 1'b1;
            else if (!do_push && advance_rd) count <= count - 1'b1;
        end
    end

    generate
        if (OVERWRITE) begin : g_ovw_chk
            p_full_after_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
                drop |=> full);
        end else begin : g_hold_chk
            p_pend_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (push && full) |-> pop);
        end
    endgenerate

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/lm_accum.sv
module lm_accum
    import lm_pkg::*;
#(
    parameter int FLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_valid,
    input  logic [FLD_W-1:0] dat_be,
    input  logic             dat_last,
    input  logic             len_mode,
    output logic             done,
    output logic [FLD_W-1:0] value
);
    acc_state_t       state, state_nx;
    logic [FLD_W-1:0] acc, acc_base;

    assign acc_base = (state == ACC_IDLE) ? '0 : acc;
    assign value    = len_mode ? acc_base + 1'b1 : (acc_base | dat_be);
    assign done     = dat_valid && dat_last;

    always_comb begin
        state_nx = state;
        unique case (state)
            ACC_IDLE: if (dat_valid && !dat_last) state_nx = ACC_RUN;
            ACC_RUN:  if (dat_valid && dat_last)  state_nx = ACC_IDLE;
            default:  state_nx = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ACC_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     acc <= '0;
        else if (dat_valid && dat_last) acc <= '0;
        else if (dat_valid)             acc <= value;
    end

    p_idle_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_last) |=> (state == ACC_IDLE));

    p_len_first_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && len_mode && state == ACC_IDLE) |-> (value == FLD_W'(1)));

endmodule

// File: rtl/late_merge_top.sv
module late_merge_top
    import lm_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int REC_W      = 32,
    parameter int FLD_W      = 8,
    parameter int FLD_LSB    = 8,
    parameter int PEND_DEPTH = 4,
    parameter int SIDE_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [REC_W-1:0] cmd_rec,
    input  logic             cmd_has_data,
    input  logic             cmd_len_mode,
    input  logic             dat_valid,
    input  logic [FLD_W-1:0] dat_be,
    input  logic             dat_last,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr,
    output logic [REC_W-1:0] mem_wdata,
    output logic [REC_W-1:0] mem_wsel,
    output logic             mem_drop
);
    localparam int PEND_W = IDX_W + 1;
    localparam int SIDE_W = IDX_W + FLD_W;
    localparam logic [REC_W-1:0] FIELD_SEL = REC_W'({FLD_W{1'b1}}) << FLD_LSB;

    grant_t            gnt;
    logic [PEND_W-1:0] pend_head;
    logic              pend_empty, pend_full, pend_drop;
    logic              head_mode;
    logic [IDX_W-1:0]  head_idx;
    logic              upd_done;
    logic [FLD_W-1:0]  upd_val;
    logic [SIDE_W-1:0] side_head;
    logic              side_empty, side_full, side_push, side_pop;

    assign head_mode = pend_head[IDX_W];
    assign head_idx  = pend_head[IDX_W-1:0];

    lm_fifo #(.W(PEND_W), .DEPTH(PEND_DEPTH), .OVERWRITE(1'b0)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_valid && cmd_has_data),
        .din   ({cmd_len_mode, cmd_idx}),
        .pop   (upd_done),
        .dout  (pend_head),
        .empty (pend_empty),
        .full  (pend_full),
        .drop  (pend_drop)
    );

    lm_accum #(.FLD_W(FLD_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .dat_valid (dat_valid),
        .dat_be    (dat_be),
        .dat_last  (dat_last),
        .len_mode  (head_mode),
        .done      (upd_done),
        .value     (upd_val)
    );

    always_comb begin
        if (cmd_valid)        gnt = GNT_CMD;
        else if (!side_empty) gnt = GNT_QUEUE;
        else if (upd_done)    gnt = GNT_DIRECT;
        else                  gnt = GNT_NONE;
    end

    assign side_pop  = (gnt == GNT_QUEUE);
    assign side_push = upd_done && (gnt != GNT_DIRECT);

    lm_fifo #(.W(SIDE_W), .DEPTH(SIDE_DEPTH), .OVERWRITE(1'b1)) u_side (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (side_push),
        .din   ({head_idx, upd_val}),
        .pop   (side_pop),
        .dout  (side_head),
        .empty (side_empty),
        .full  (side_full),
        .drop  (mem_drop)
    );

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wsel  = '0;
        unique case (gnt)
            GNT_CMD: begin
                mem_we    = 1'b1;
                mem_addr  = cmd_idx;
                mem_wdata = cmd_rec & ~FIELD_SEL;
                mem_wsel  = '1;
            end
            GNT_QUEUE: begin
                mem_we    = 1'b1;
                mem_addr  = side_head[SIDE_W-1:FLD_W];
                mem_wdata = REC_W'(side_head[FLD_W-1:0]) << FLD_LSB;
                mem_wsel  = FIELD_SEL;
            end
            GNT_DIRECT: begin
                mem_we    = 1'b1;
                mem_addr  = head_idx;
                mem_wdata = REC_W'(upd_val) << FLD_LSB;
                mem_wsel  = FIELD_SEL;
            end
            default: ;
        endcase
    end

    p_cmd_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (mem_we && mem_addr == cmd_idx && mem_wsel == '1));

    p_field_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((mem_wdata & FIELD_SEL) == '0));

    p_queue_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !side_empty) |-> (mem_we && mem_wsel == FIELD_SEL));

    p_beat_has_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> !pend_empty);

    p_drop_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drop |-> (upd_done && cmd_valid));

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !dat_valid && side_empty) |-> (!mem_we && !mem_drop));

endmodule

// File: tb/tb_late_merge_top.sv
module tb_late_merge_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_has_data, cmd_len_mode;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_rec;
    logic        dat_valid, dat_last;
    logic [7:0]  dat_be;
    logic        mem_we, mem_drop;
    logic [5:0]  mem_addr;
    logic [31:0] mem_wdata, mem_wsel;

    localparam logic [31:0] FSEL = 32'h0000FF00;

    late_merge_top dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_rec(cmd_rec),
        .cmd_has_data(cmd_has_data), .cmd_len_mode(cmd_len_mode),
        .dat_valid(dat_valid), .dat_be(dat_be), .dat_last(dat_last),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wsel(mem_wsel), .mem_drop(mem_drop)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [6:0]  pq[$];
    logic [13:0] sq[$];
    logic [7:0]  macc = 8'h0;
    int          drop_seen;
    logic [5:0]  fw_log[16];
    int          fw_n;
    logic        last_we;
    logic [5:0]  last_addr;
    logic [31:0] last_wdata, last_wsel;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] acc_value(input logic mode, input logic [7:0] base, input logic [7:0] be);
        return mode ? base + 8'd1 : (base | be);
    endfunction

    task automatic step(input logic cv, input logic [5:0] ci, input logic [31:0] cr,
                        input logic chd, input logic cm, input logic dv,
                        input logic [7:0] dbe, input logic dl);
        int g;
        logic done;
        logic [7:0] val;
        logic [5:0] ea;
        logic [31:0] ed, es;
        logic edrop;
        string tag;
        @(negedge clk);
        cmd_valid = cv; cmd_idx = ci; cmd_rec = cr; cmd_has_data = chd; cmd_len_mode = cm;
        dat_valid = dv; dat_be = dbe; dat_last = dl;
        #1;
        done = dv && dl;
        val  = (pq.size() > 0) ? acc_value(pq[0][6], macc, dbe) : 8'h0;
        if (cv)                 g = 1;
        else if (sq.size() > 0) g = 2;
        else if (done)          g = 3;
        else                    g = 0;
        ea = '0; ed = '0; es = '0; tag = "R1";
        case (g)
            1: begin ea = ci; ed = cr & ~FSEL; es = 32'hFFFFFFFF; tag = "R2/R3"; end
            2: begin ea = sq[0][13:8]; ed = {16'h0, sq[0][7:0], 8'h0}; es = FSEL; tag = "R8"; end
            3: begin ea = pq[0][5:0]; ed = {16'h0, val, 8'h0}; es = FSEL; tag = "R6"; end
            default: ;
        endcase
        edrop = done && (g == 1) && (sq.size() == 4);
        chk(mem_we === (g != 0), tag, 64'(mem_we), 64'(g != 0));
        if (g != 0) begin
            chk(mem_addr === ea, tag, 64'(mem_addr), 64'(ea));
            chk(mem_wdata === ed, tag, 64'(mem_wdata), 64'(ed));
            chk(mem_wsel === es, tag, 64'(mem_wsel), 64'(es));
        end
        chk(mem_drop === edrop, "R9", 64'(mem_drop), 64'(edrop));
        last_we = mem_we; last_addr = mem_addr; last_wdata = mem_wdata; last_wsel = mem_wsel;
        if (mem_drop) drop_seen++;
        if (mem_we && mem_wsel == FSEL && fw_n < 16) begin
            fw_log[fw_n] = mem_addr;
            fw_n++;
        end
        if (done) begin
            if (g != 3) sq.push_back({pq[0][5:0], val});
            void'(pq.pop_front());
        end
        if (g == 2) void'(sq.pop_front());
        if (sq.size() > 4) void'(sq.pop_front());
        if (cv && chd) pq.push_back({cm, ci});
        if (dv) macc = dl ? 8'h0 : val;
    endtask

    task automatic idle();
        step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    endtask

    task automatic flush();
        while (pq.size() > 0) step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h01, 1'b1);
        for (int i = 0; i < 6; i++) idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0;
        cmd_valid = 0; cmd_idx = 0; cmd_rec = 0; cmd_has_data = 0; cmd_len_mode = 0;
        dat_valid = 0; dat_be = 0; dat_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: quiet after reset
        idle();
        chk(last_we === 1'b0, "R1", 64'(last_we), 64'd0);

        // R2, R3: command record written at once, field zeroed
        step(1'b1, 6'd7, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
        chk(last_addr === 6'd7 && last_wdata === 32'hDEAD00EF, "R3", 64'(last_wdata), 64'hDEAD00EF);

        // R4: mask mode accumulation
        step(1'b1, 6'd9, 32'h12345678, 1'b1, 1'b0, 1'b0, 8'h0, 1'b0);
        step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0);
        step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h04, 1'b0);
        step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1);
        chk(last_we && last_addr === 6'd9 && last_wdata === 32'h00008500, "R4", 64'(last_wdata), 64'h8500);
        chk(last_wsel === FSEL, "R6", 64'(last_wsel), 64'(FSEL));

        // R5: length mode counts beats
        step(1'b1, 6'd33, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 8'h0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
        chk(last_addr === 6'd33 && last_wdata === 32'h00000500, "R5", 64'(last_wdata), 64'h500);

        // R7: update completing under a command is parked
        step(1'b1, 6'd3, 32'h0, 1'b1, 1'b0, 1'b0, 8'h0, 1'b0);
        step(1'b1, 6'd4, 32'hAAAAAAAA, 1'b0, 1'b0, 1'b1, 8'h0F, 1'b1);
        chk(last_addr === 6'd4 && last_wsel === 32'hFFFFFFFF, "R7", 64'(last_addr), 64'd4);
        idle();
        chk(last_we && last_addr === 6'd3 && last_wdata === 32'h00000F00, "R7", 64'(last_wdata), 64'hF00);

        // R10: command without data takes no beats
        step(1'b1, 6'd20, 32'h0, 1'b1, 1'b0, 1'b0, 8'h0, 1'b0);
        step(1'b1, 6'd21, 32'h0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
        step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h02, 1'b1);
        chk(last_addr === 6'd20 && last_wdata === 32'h00000200, "R10", 64'(last_addr), 64'd20);

        // R9, R8: overflow of the side queue, then ordered drain
        flush();
        drop_seen = 0; fw_n = 0;
        step(1'b1, 6'd10, 32'h0, 1'b1, 1'b0, 1'b0, 8'h0, 1'b0);
        for (int k = 1; k <= 6; k++)
            step(1'b1, 6'(10 + k), 32'h0, 1'b1, 1'b0, 1'b1, 8'(1 << k), 1'b1);
        chk(drop_seen == 2, "R9", 64'(drop_seen), 64'd2);
        step(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h01, 1'b1);
        for (int i = 0; i < 6; i++) idle();
        chk(fw_n == 5, "R9", 64'(fw_n), 64'd5);
        for (int i = 0; i < 5; i++)
            chk(fw_log[i] === 6'(12 + i), "R8", 64'(fw_log[i]), 64'(12 + i));

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic cv, chd, dv, dl;
            cv  = ($urandom % 3) == 0;
            chd = cv && (pq.size() < 4) && ($urandom % 2);
            dv  = (pq.size() > 0) && (($urandom % 2) == 0);
            dl  = ($urandom % 3) == 0;
            step(cv, 6'($urandom), $urandom, chd, 1'($urandom), dv, 8'($urandom), dl);
        end
        flush();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule